// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM with Selectable Read Latency

This block is a clocked single-port memory with a common data bus. Address, write data, the three chip enables and the write controls are all captured on the rising clock edge. A captured write updates the array on the following edge. A write can target selected byte lanes, or it can target the whole word through a global-write control that ignores the lane selects. Each lane is nine bits wide, eight data bits plus one parity bit. The default 18-bit word therefore holds two lanes: lane 0 is bits [8:0] and lane 1 is bits [17:9].

The `pipe_mode` input sets the read latency. When it is low, read data comes straight from the array in the cycle after the read is captured (flow-through). When it is high, read data passes through a rising-edge output register and appears one cycle later (pipelined).

Deselect uses single-cycle timing. The bus stops driving in the cycle right after a deselect or a write has been captured, even if a pipelined read is still waiting to be shown. The output enable and the sleep input both act asynchronously on the drivers. While sleep is high, commands at clock edges are ignored and the stored contents are kept.

The tri-state bus is modelled as `din`, `dout` and a drive enable `dout_en`. Burst address generation takes place outside this block.

Top module: `bwsram_top`

## Requirements
- R1: A command is accepted only when `cs_hi`=1, `cs_a_n`=0 and `cs_b_n`=0 at the clock edge. Any other combination is a deselect: nothing is written, and the bus is not driven in the following cycle.
- R2: When `wr_all`=1 at a selected edge, all lanes of `din` are written to `addr`, whatever `wr_bytes` and `lane_sel` hold.
- R3: When `wr_bytes`=1 at a selected edge, only the lanes whose `lane_sel` bit is 1 are written. Lane i is bits [9i+8:9i]. If `wr_bytes`=1 with `lane_sel`=0 and `wr_all`=0, the command is a read.
- R4: With `pipe_mode`=0, a read captured at edge k drives the addressed word on `dout` with `dout_en`=1 from edge k until edge k+1. Data written by an earlier command is visible.
- R5: With `pipe_mode`=1, a read captured at edge k drives its word from edge k+1 until edge k+2, provided the command captured at edge k+1 is a selected read.
- R6: A deselect captured at edge k turns `dout_en` off from edge k onward in either mode. This suppresses a pipelined read captured at edge k-1.
- R7: `oe`=0 forces `dout_en` to 0 at once, without waiting for a clock edge.
- R8: `sleep`=1 forces `dout_en` to 0 at once. Commands at edges while `sleep`=1 are ignored, and stored words are unchanged after `sleep` returns to 0.
- R9: While `rst` is high, and after it, the bus is not driven until a read has been captured.
- R10: In the cycle after a write has been captured, `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the control stages |
| addr | input | 8 | Word address |
| cs_hi | input | 1 | Chip enable, active high |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b_n | input | 1 | Chip enable, active low |
| wr_all | input | 1 | Global write of every lane |
| wr_bytes | input | 1 | Lane-write enable, qualified by lane_sel |
| lane_sel | input | 2 | Per-lane write selects |
| din | input | 18 | Write data |
| pipe_mode | input | 1 | 1 = pipelined read, 0 = flow-through read |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous low-power hold, active high |
| dout | output | 18 | Read data, zero when not driving |
| dout_en | output | 1 | Bus drive enable |

## Verification
In flow-through mode, a read is due in the cycle that opens with its own capture edge. In pipelined mode it is due one cycle later, and only if the next command is a selected read. Deselects and writes switch the bus off in the cycle that opens with their capture edge. The driver computes the due cycle from the edge each command is captured on and queues it. It settles a pending pipelined read only when it issues the next command. The monitor compares just after each edge, and only entries whose due cycle has arrived. The oe and sleep cases are probed in the middle of a cycle, because they must act without any edge.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic {
        RD_FLOW = 1'b0,
        RD_PIPE = 1'b1
    } rdmode_e;

    typedef struct packed {
        logic              sel;
        logic              rd;
        logic              wr;
        logic [LANES-1:0]  lanes;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } cmd_t;

    function automatic logic chip_hit(input logic hi, input logic a_n, input logic b_n);
        return hi & ~a_n & ~b_n;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic all,
                                                   input logic bytes,
                                                   input logic [LANES-1:0] sel);
        if (all)
            return '1;
        else if (bytes)
            return sel;
        else
            return '0;
    endfunction

endpackage

// File: rtl/bwsram_capture.sv
module bwsram_capture
    import bwsram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_hi,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic              wr_all,
    input  logic              wr_bytes,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [WORD_W-1:0] din,
    output cmd_t              cmd_q
);

    logic             hit;
    logic [LANES-1:0] mask;

    always_comb begin
        hit  = chip_hit(cs_hi, cs_a_n, cs_b_n) & ~sleep;
        mask = lane_mask(wr_all, wr_bytes, lane_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else begin
            cmd_q.sel   <= hit;
            cmd_q.wr    <= hit & (|mask);
            cmd_q.rd    <= hit & ~(|mask);
            cmd_q.lanes <= mask;
            cmd_q.addr  <= addr;
            cmd_q.data  <= din;
        end
    end

endmodule

// File: rtl/bwsram_array.sv
module bwsram_array
    import bwsram_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lanes,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && lanes[g])
                store[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = store[addr];
    end

endmodule

// File: rtl/bwsram_outstage.sv
module bwsram_outstage
    import bwsram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rdmode_e           mode,
    input  logic              oe,
    input  logic              sleep,
    input  logic              q_sel,
    input  logic              q_rd,
    input  logic              q_wr,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    logic              held_v;
    logic [WORD_W-1:0] held_d;
    logic              live;
    logic [WORD_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v <= 1'b0;
            held_d <= '0;
        end else begin
            held_v <= q_rd;
            if (q_rd)
                held_d <= rdata;
        end
    end

    always_comb begin
        unique case (mode)
            RD_FLOW: begin
                live = q_rd;
                word = rdata;
            end
            RD_PIPE: begin
                live = held_v & q_sel & ~q_wr;
                word = held_d;
            end
            default: begin
                live = 1'b0;
                word = '0;
            end
        endcase
        dout_en = live & oe & ~sleep;
        dout    = dout_en ? word : '0;
    end

endmodule

// File: rtl/bwsram_top.sv
module bwsram_top
    import bwsram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_hi,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic              wr_all,
    input  logic              wr_bytes,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [WORD_W-1:0] din,
    input  logic              pipe_mode,
    input  logic              oe,
    input  logic              sleep,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);

    cmd_t              cmd_q;
    logic [WORD_W-1:0] rdata;
    rdmode_e           mode;

    assign mode = rdmode_e'(pipe_mode);

    bwsram_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .sleep    (sleep),
        .addr     (addr),
        .cs_hi    (cs_hi),
        .cs_a_n   (cs_a_n),
        .cs_b_n   (cs_b_n),
        .wr_all   (wr_all),
        .wr_bytes (wr_bytes),
        .lane_sel (lane_sel),
        .din      (din),
        .cmd_q    (cmd_q)
    );

    bwsram_array u_mem (
        .clk   (clk),
        .wr_en (cmd_q.wr),
        .lanes (cmd_q.lanes),
        .addr  (cmd_q.addr),
        .wdata (cmd_q.data),
        .rdata (rdata)
    );

    bwsram_outstage u_out (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .oe      (oe),
        .sleep   (sleep),
        .q_sel   (cmd_q.sel),
        .q_rd    (cmd_q.rd),
        .q_wr    (cmd_q.wr),
        .rdata   (rdata),
        .dout    (dout),
        .dout_en (dout_en)
    );

endmodule

// File: rtl/bwsram_chk.sv
module bwsram_chk
    import bwsram_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_hi,
    input logic             cs_a_n,
    input logic             cs_b_n,
    input logic             wr_all,
    input logic             wr_bytes,
    input logic [LANES-1:0] lane_sel,
    input logic             pipe_mode,
    input logic             oe,
    input logic             sleep,
    input logic             dout_en
);

    logic sel_in;
    logic wr_in;

    assign sel_in = cs_hi & ~cs_a_n & ~cs_b_n;
    assign wr_in  = wr_all | (wr_bytes & (|lane_sel));

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !dout_en);

    // R8
    sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dout_en);

    // R9
    reset_off_chk: assert property (@(posedge clk)
        rst |=> !dout_en);

    // R10
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_in && wr_in && !sleep) |=> !dout_en);

    // R6 and R1
    deselect_off_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_in |=> !dout_en);

    // R4
    flow_due_chk: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && sel_in && !wr_in && !sleep) ##1 (!pipe_mode && oe && !sleep)
        |-> dout_en);

    // R5
    pipe_due_chk: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && sel_in && !wr_in && !sleep)
        ##1 (pipe_mode && sel_in && !wr_in && !sleep)
        ##1 (pipe_mode && oe && !sleep)
        |-> dout_en);

endmodule

bind bwsram_top bwsram_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cs_hi     (cs_hi),
    .cs_a_n    (cs_a_n),
    .cs_b_n    (cs_b_n),
    .wr_all    (wr_all),
    .wr_bytes  (wr_bytes),
    .lane_sel  (lane_sel),
    .pipe_mode (pipe_mode),
    .oe        (oe),
    .sleep     (sleep),
    .dout_en   (dout_en)
);

// File: tb/bwsram_top_tb_top.sv
module bwsram_top_tb_top;
    import bwsram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              cs_hi = 1'b0;
    logic              cs_a_n = 1'b1;
    logic              cs_b_n = 1'b1;
    logic              wr_all = 1'b0;
    logic              wr_bytes = 1'b0;
    logic [LANES-1:0]  lane_sel = '0;
    logic [WORD_W-1:0] din = '0;
    logic              pipe_mode = 1'b0;
    logic              oe = 1'b1;
    logic              sleep = 1'b0;
    logic [WORD_W-1:0] dout;
    logic              dout_en;

    bwsram_top dut_i (
        .clk(clk), .rst(rst), .addr(addr), .cs_hi(cs_hi), .cs_a_n(cs_a_n),
        .cs_b_n(cs_b_n), .wr_all(wr_all), .wr_bytes(wr_bytes), .lane_sel(lane_sel),
        .din(din), .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep),
        .dout(dout), .dout_en(dout_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int                due;
        logic              en;
        logic [WORD_W-1:0] data;
        string             tag;
    } exp_t;

    exp_t              sb[$];
    exp_t              pend;
    bit                pend_v = 1'b0;
    logic [WORD_W-1:0] model [DEPTH];
    int                cyc = 0;
    int                n_chk = 0;
    int                n_fail = 0;
    bit                done = 1'b0;

    task automatic check(input string tag, input logic en_exp, input logic [WORD_W-1:0] d_exp);
        n_chk++;
        if (dout_en !== en_exp || (en_exp && dout !== d_exp)) begin
            n_fail++;
            $display("FAIL %s: dout_en=%b dout=%h, expected dout_en=%b dout=%h",
                     tag, dout_en, dout, en_exp, d_exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: pops entries as their due cycle arrives
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t it;
                it = sb.pop_front();
                if (it.due == cyc) begin
                    check(it.tag, it.en, it.data);
                end else begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL %s: entry due at %0d missed, now %0d", it.tag, it.due, cyc);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run still active after %0d cycles, expected completion", WATCHDOG_CYCLES);
        finish_run();
    end

    // driver: one command per cycle, expectations queued by due cycle
    task automatic issue(input logic c_hi, input logic c_an, input logic c_bn,
                         input logic wa, input logic wb, input logic [LANES-1:0] ls,
                         input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d,
                         input string tag);
        int               e;
        logic             hit;
        logic             wr;
        logic [LANES-1:0] m;
        @(negedge clk);
        cs_hi = c_hi; cs_a_n = c_an; cs_b_n = c_bn;
        wr_all = wa; wr_bytes = wb; lane_sel = ls; addr = a; din = d;
        e   = cyc + 1;
        hit = c_hi && !c_an && !c_bn && !sleep;
        m   = wa ? '1 : (wb ? ls : '0);
        wr  = hit && (m != '0);
        if (pend_v) begin
            pend.en = hit && !wr && oe;
            sb.push_back(pend);
            pend_v = 1'b0;
        end
        if (!hit) begin
            sb.push_back('{e, 1'b0, '0, tag});
        end else if (wr) begin
            for (int l = 0; l < LANES; l++)
                if (m[l]) model[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
            sb.push_back('{e, 1'b0, '0, tag});
        end else if (!pipe_mode) begin
            sb.push_back('{e, oe, model[a], tag});
        end else begin
            pend   = '{e + 1, 1'b1, model[a], tag};
            pend_v = 1'b1;
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, a, '0, tag);
    endtask

    task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d, input string tag);
        issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, a, d, tag);
    endtask

    task automatic idle(input string tag);
        issue(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0, '0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset", 1'b0, '0);
        rst = 1'b0;

        // flow-through, global writes and reads
        wr_word(8'd3, 18'h12345, "R2");
        wr_word(8'd5, 18'h2ABCD, "R2");
        rd(8'd3, "R4");
        rd(8'd5, "R4");

        // lane writes
        issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 8'd3, 18'h3FFFF, "R3");
        rd(8'd3, "R3");
        issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 8'd5, 18'h00000, "R3");
        rd(8'd5, "R3");
        // global write overrides lane selects
        issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 8'd5, 18'h15A5A, "R2");
        rd(8'd5, "R2");
        // lane-write enable with no lanes selected acts as a read
        issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 8'd3, 18'h00000, "R3");

        // partial chip enables are deselects
        issue(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 8'd3, 18'h00001, "R1");
        issue(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 8'd3, 18'h00002, "R1");
        issue(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, 8'd3, 18'h00003, "R1");
        rd(8'd3, "R1");

        // asynchronous output enable
        rd(8'd5, "R4");
        @(posedge clk); #2;
        oe = 1'b0;
        #1 check("R7 oe low", 1'b0, '0);
        oe = 1'b1;
        idle("R6");

        // pipelined mode
        @(negedge clk);
        pipe_mode = 1'b1;
        rd(8'd3, "R5");
        rd(8'd5, "R5");
        rd(8'd3, "R6 read before deselect");
        idle("R6");
        rd(8'd5, "R10 read before write");
        wr_word(8'd7, 18'h0BEEF, "R10");
        rd(8'd7, "R5");
        rd(8'd7, "R5");
        idle("R6");

        // sleep
        @(negedge clk);
        pipe_mode = 1'b0;
        sleep = 1'b1;
        wr_word(8'd7, 18'h3C3C3, "R8 write in sleep");
        rd(8'd7, "R8 read in sleep");
        @(negedge clk);
        sleep = 1'b0;
        rd(8'd7, "R8 retained");
        rd(8'd3, "R4");
        @(posedge clk); #2;
        sleep = 1'b1;
        #1 check("R8 async sleep", 1'b0, '0);
        sleep = 1'b0;
        idle("R6");

        repeat (3) @(negedge clk);
        if (sb.size() != 0 || pend_v) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: %0d entries left, expected 0", sb.size());
        end
        finish_run();
    end

endmodule